// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

This block turns a raw "both alert tones present" flag into a qualified alert level. It rejects detections that are too short and covers brief dropouts in a detection that has already qualified. Two independent guard intervals set the behaviour. The output rises only after the raw flag has stayed high for the whole present interval. It falls only after the raw flag has stayed low for the whole absent interval. Both intervals are counted in cycles of the 3.579545 MHz system clock and are supplied on input ports, so firmware strapping or a neighbouring block can set them.

A single cycle counter measures the current run of raw samples that disagree with the qualified output. Any sample that agrees with the output restarts the run. The counter also returns to zero as soon as the output changes, so each new qualification starts from zero. A sleep input forces the output low and the counter idle on the next clock edge. An optional one-cycle change pulse marks every transition of the output. The qualified level is meant to feed an interrupt combiner.

Top module: `tone_guard_qualifier`

## Requirements
- R1: After a synchronous active-high reset, `alertOut` and `alertChange` are 0.
- R2: With `alertOut` low, `alertOut` goes high right after the clock edge that samples `rawDetect` high for the `presentGuard`-th consecutive time.
- R3: A high run of `rawDetect` shorter than `presentGuard` samples, followed by a low sample, leaves `alertOut` low.
- R4: With `alertOut` high, `alertOut` goes low right after the edge that samples `rawDetect` low for the `absentGuard`-th consecutive time.
- R5: A low dropout of `rawDetect` shorter than `absentGuard` samples leaves `alertOut` high.
- R6: The present and absent intervals act independently. Different values on the two ports give different run lengths for a rise and for a fall.
- R7: Inside a guard interval, a single sample equal to the current output level restarts the count. Only an unbroken run of the opposite level qualifies.
- R8: The counter restarts when the output changes. The first opposite-level sample after a change is counted as sample 1 of the new interval.
- R9: While `sleep` is high, `alertOut` is 0 after the next edge and any partial count is discarded. Once sleep ends, a full `presentGuard` run is needed again.
- R10: `alertChange` is high for exactly the cycle that follows each change of `alertOut`, including a fall forced by sleep, and is low otherwise.
- R11: A guard value of 0 or 1 makes the output follow a single opposite-level sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (3.579545 MHz in the target system) |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Forces the qualified output low and the counter idle |
| rawDetect | input | 1 | Unqualified dual-tone detect flag |
| presentGuard | input | CNT_W (20) | Present guard interval in clock cycles |
| absentGuard | input | CNT_W (20) | Absent guard interval in clock cycles |
| alertOut | output | 1 | Qualified alert level |
| alertChange | output | 1 | One-cycle pulse after each change of alertOut |

## Verification
The bench aims at the off-by-one edges of both intervals. A run one sample short of the present interval must not qualify, and a run of exactly that length must. A design that counts one cycle too many or too few shifts the rise or the fall by a cycle and is caught at once. Dropouts that return to the output level must restart the count; a design that only pauses the count would qualify early. A sleep pulse in the middle of a run must discard the partial count and, if the output was high, drop it with a change pulse. Guard values of 0 and 1 are checked so that a design that wraps its compare on 0 would hang or toggle at the wrong time.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef struct packed {
    logic clearCnt;
    logic incCnt;
    logic flipOut;
    logic forceLow;
  } guard_strobe_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import guard_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  guard_strobe_t    strobe,
  input  logic             selAbsent,
  input  logic [CNT_W-1:0] presentGuard,
  input  logic [CNT_W-1:0] absentGuard,
  output logic             expire
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] target;
  logic [EXT_W-1:0] nextCount;

  // The interval is chosen by the current output level: high waits for absence.
  always_comb begin
    target    = selAbsent ? absentGuard : presentGuard;
    nextCount = {1'b0, runCnt} + EXT_W'(1);
    expire    = nextCount >= {1'b0, target};
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clearCnt) runCnt <= '0;
    else if (strobe.incCnt)     runCnt <= runCnt + CNT_W'(1);
  end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter bit CHANGE_PULSE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          rawDetect,
  input  logic          expire,
  output guard_strobe_t strobe,
  output logic          level,
  output logic          changePulse
);
  logic mismatch;
  logic nextLevel;

  always_comb begin
    mismatch        = rawDetect ^ level;
    strobe.forceLow = sleep;
    strobe.flipOut  = !sleep && mismatch && expire;
    strobe.incCnt   = !sleep && mismatch && !expire;
    strobe.clearCnt = sleep || !mismatch || expire;
    if (strobe.forceLow)     nextLevel = 1'b0;
    else if (strobe.flipOut) nextLevel = !level;
    else                     nextLevel = level;
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else     level <= nextLevel;
  end

  generate
    if (CHANGE_PULSE) begin : g_pulse
      logic pulseReg;
      always_ff @(posedge clk) begin
        if (rst) pulseReg <= 1'b0;
        else     pulseReg <= nextLevel != level;
      end
      assign changePulse = pulseReg;
    end else begin : g_nopulse
      assign changePulse = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tone_guard_qualifier.sv
module tone_guard_qualifier
  import guard_pkg::*;
#(
  parameter int CNT_W        = 20,
  parameter bit CHANGE_PULSE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             rawDetect,
  input  logic [CNT_W-1:0] presentGuard,
  input  logic [CNT_W-1:0] absentGuard,
  output logic             alertOut,
  output logic             alertChange
);
  guard_strobe_t strobe;
  logic          expire;
  logic          level;

  guard_ctrl #(.CHANGE_PULSE(CHANGE_PULSE)) u_ctrl (
    .clk(clk), .rst(rst), .sleep(sleep), .rawDetect(rawDetect),
    .expire(expire), .strobe(strobe), .level(level), .changePulse(alertChange)
  );

  guard_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .selAbsent(level),
    .presentGuard(presentGuard), .absentGuard(absentGuard), .expire(expire)
  );

  assign alertOut = level;
endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter bit CHANGE_PULSE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic sleep,
  input logic rawDetect,
  input logic alertOut,
  input logic alertChange
);
  // R9: sleep forces the output low at the next edge
  assert_sleep_low_R9: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !alertOut);

  // R2: a rise needs the raw flag high on the qualifying edge
  assert_rise_needs_raw_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(alertOut) |-> $past(rawDetect));

  // R4: a fall not caused by sleep needs the raw flag low
  assert_fall_needs_raw_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(alertOut) && !$past(sleep)) |-> !$past(rawDetect));

  // R7: a sample that agrees with the output never changes it
  assert_agree_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!sleep && (rawDetect == alertOut)) |=> $stable(alertOut));

  generate
    if (CHANGE_PULSE) begin : g_chk_pulse
      // R10: pulse marks exactly the cycles after an output change
      assert_pulse_match_R10: assert property (@(posedge clk) disable iff (rst)
        ##1 (alertChange == (alertOut != $past(alertOut))));
    end
  endgenerate
endmodule

bind tone_guard_qualifier guard_checker #(.CHANGE_PULSE(CHANGE_PULSE)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep), .rawDetect(rawDetect),
  .alertOut(alertOut), .alertChange(alertChange)
);

// File: tb/tone_guard_qualifier_tb.sv
module tone_guard_qualifier_tb;
  localparam int CNT_W = 20;

  typedef struct {
    logic  expOut;
    logic  expChg;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0;
  logic rawDetect = 1'b0;
  logic [CNT_W-1:0] presentGuard = CNT_W'(5);
  logic [CNT_W-1:0] absentGuard  = CNT_W'(3);
  logic alertOut;
  logic alertChange;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  exp_t expQ[$];

  // reference state, derived from the requirements
  logic mOut = 1'b0;
  int   mRun = 0;

  always #5 clk = ~clk;

  tone_guard_qualifier #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .sleep(sleep), .rawDetect(rawDetect),
    .presentGuard(presentGuard), .absentGuard(absentGuard),
    .alertOut(alertOut), .alertChange(alertChange)
  );

  task automatic step(input logic raw, input logic slp, input string tag);
    exp_t e;
    int g;
    @(negedge clk);
    rawDetect = raw;
    sleep = slp;
    e.tag = tag;
    e.expChg = 1'b0;
    if (slp) begin
      e.expChg = mOut;
      mOut = 1'b0;
      mRun = 0;
    end else if (raw != mOut) begin
      mRun++;
      g = mOut ? int'(absentGuard) : int'(presentGuard);
      if (g < 1) g = 1;
      if (mRun >= g) begin
        mOut = !mOut;
        e.expChg = 1'b1;
        mRun = 0;
      end
    end else begin
      mRun = 0;
    end
    e.expOut = mOut;
    expQ.push_back(e);
  endtask

  task automatic run(input logic raw, input int n, input string tag);
    for (int i = 0; i < n; i++) step(raw, 1'b0, tag);
  endtask

  // monitor: compares one expected item per clock edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (alertOut !== e.expOut || alertChange !== e.expChg) begin
          errors++;
          $display("FAIL %s: alertOut=%b alertChange=%b expected %b %b",
                   e.tag, alertOut, alertChange, e.expOut, e.expChg);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (alertOut !== 1'b0 || alertChange !== 1'b0) begin
      errors++;
      $display("FAIL R1: alertOut=%b alertChange=%b expected 0 0", alertOut, alertChange);
    end
    rst = 1'b0;
    run(1'b0, 3, "R1");
    run(1'b1, 4, "R3");          // one short of present guard
    run(1'b0, 2, "R3");
    run(1'b1, 5, "R2");          // exact present guard -> rise
    run(1'b1, 2, "R2");
    run(1'b0, 2, "R5");          // dropout shorter than absent guard
    run(1'b1, 1, "R5");
    run(1'b0, 3, "R4");          // exact absent guard (3) -> fall, differs from 5: R6
    run(1'b0, 2, "R6");
    run(1'b1, 4, "R7");
    run(1'b0, 1, "R7");          // restart inside present interval
    run(1'b1, 4, "R7");
    run(1'b1, 1, "R7");          // fifth unbroken sample -> rise
    run(1'b0, 2, "R8");          // new interval counts from zero
    run(1'b1, 1, "R8");
    run(1'b0, 3, "R8");
    run(1'b1, 5, "R10");
    step(1'b1, 1'b1, "R10");     // sleep-forced fall with pulse
    run(1'b1, 4, "R9");
    step(1'b1, 1'b1, "R9");      // partial count discarded
    run(1'b1, 4, "R9");
    run(1'b1, 1, "R9");
    run(1'b1, 2, "R9");
    run(1'b0, 3, "R4");
    @(negedge clk);
    presentGuard = CNT_W'(1);
    absentGuard  = CNT_W'(0);
    run(1'b1, 1, "R11");
    run(1'b0, 1, "R11");
    run(1'b1, 2, "R11");
    run(1'b0, 1, "R11");
    run(1'b0, 2, "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule